// File: doc/BRIEF.md
# Low-Power Compare Timer

This block is a timer built around a wide up-counter. It advances on ticks from one of four slow clock sources, each of which reaches the block as a single-cycle enable pulse in the system clock domain. Ticks go to the counter either directly or through a power-of-two prescaler. The running count is compared with a programmable compare value. When the two match, the block sets a sticky compare flag, can assert an interrupt, and drives a hardware trigger output.

Software controls the block through four word registers on a simple write/read port. A control/status word holds the run enable, the counting mode, the overflow behaviour, the interrupt enable and the compare flag. A configuration word holds the source select, the prescaler bypass and the prescaler exponent. The other two registers are the compare value and the count snapshot. To read the count, software writes any value to the snapshot register, which captures the live count, and then reads the snapshot back. Clearing the run bit returns all counting state to zero.

Top module: `lp_cmp_timer`

Register map, selected by `bus_addr`:
- Address 0, control/status: bit 0 run, bit 1 pulse mode, bit 2 free-running, bit 3 interrupt enable, bit 7 compare flag.
- Address 1, configuration: bits 1:0 source, bit 2 bypass, bits 6:3 prescaler exponent.
- Address 2, compare value.
- Address 3, count snapshot.

## Requirements
- R1: After reset, all four registers read zero and both `irq_o` and `trig_o` are low.
- R2: Configuration bits 1:0 select which bit of `src_tick_i` is counted. Pulses on the other three bits have no effect on the count.
- R3: When configuration bit 2 (bypass) is set, the count advances by one per counted tick. When bypass is clear, the count advances once per 2^(E+1) counted ticks, where E is configuration bits 6:3.
- R4: After the run bit rises, the first two selected source pulses only warm up the synchroniser and do not advance the count or the prescaler.
- R5: A write of any value to address 3 copies the live count into the snapshot. Reads of address 3 return that copy, which does not change until the next write to address 3.
- R6: A counted tick that finds the count equal to the compare value sets the compare flag (control bit 7). Writing 1 to control bit 7 clears the flag; writing 0 leaves it unchanged.
- R7: With control bit 2 clear, the tick that sets the flag also returns the count to zero. With control bit 2 set, the count keeps incrementing and wraps only at its full range.
- R8: `irq_o` is high exactly when the compare flag is set and control bit 3 is set.
- R9: `trig_o` is high while the run bit is set and the count equals the compare value. With a compare value of zero in compare-reset mode, `trig_o` therefore stays high until the run bit is cleared.
- R10: While the run bit is set and the flag is clear, writes to address 2 are ignored. While the flag is set, or while the run bit is clear, they take effect.
- R11: Clearing the run bit clears the count, the compare flag, the prescaler and the warm-up state. The snapshot register keeps its value.
- R12: With control bit 1 set (pulse mode), the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` |
| src_tick_i | input | 4 | Slow clock sources as single-cycle enable pulses |
| irq_o | output | 1 | Compare interrupt |
| trig_o | output | 1 | Hardware trigger (count equals compare while running) |

## Verification
The counting path is driven with bursts on the selected source, with pulses on a source that is not selected, and with divide-by-four prescaling. Comparing the snapshot values these produce separates the selected input from the others, bypass from division, and the two warm-up pulses from real counts. The compare path is run in both overflow modes with the same compare value, which distinguishes reset-on-match from free running. The bench also tries compare writes with the flag clear and with it set, and runs with a compare value of zero to hold the trigger high. Disable and pulse-mode runs show whether the state is cleared or frozen.

// File: rtl/lp_cmp_timer_pkg.sv
// Package: shared constants for the low-power compare timer.
// Assumes a four-word register window selected by a 2-bit address.
package lp_cmp_timer_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_SNAP = 2'd3;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_PULSE = 1;
    localparam int CTRL_FREE  = 2;
    localparam int CTRL_IE    = 3;
    localparam int CTRL_FLAG  = 7;

    localparam int CFG_BYP = 2;
    localparam int CFG_EXP_LSB = 3;

    typedef struct packed {
        logic       run;
        logic       pulse_mode;
        logic       free_run;
        logic       irq_en;
    } ctrl_t;
endpackage

// File: rtl/lp_cmp_timer_regs.sv
// Module: register file of the timer.
// Holds control, configuration, compare and snapshot words and decodes
// writes. The compare write is gated: it is accepted when stopped or
// while the compare flag is set. Assumes single-cycle write strobes.
module lp_cmp_timer_regs
    import lp_cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SRC_N = 4,
    parameter int PSC_W = 4,
    localparam int SEL_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag,
    output ctrl_t            ctrl,
    output logic [SEL_W-1:0] src_sel,
    output logic             bypass,
    output logic [PSC_W-1:0] psc_exp,
    output logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] snap_val,
    output logic             flag_clr
);
    logic wr_ctrl, wr_cfg, wr_cmp, wr_snap;

    // Decode write strobes per register.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
        wr_cmp  = bus_wr && (bus_addr == ADDR_CMP) && (!ctrl.run || flag);
        wr_snap = bus_wr && (bus_addr == ADDR_SNAP);
        flag_clr = wr_ctrl && bus_wdata[CTRL_FLAG];
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.run        <= bus_wdata[CTRL_RUN];
            ctrl.pulse_mode <= bus_wdata[CTRL_PULSE];
            ctrl.free_run   <= bus_wdata[CTRL_FREE];
            ctrl.irq_en     <= bus_wdata[CTRL_IE];
        end
    end

    // Configuration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= '0;
            bypass  <= 1'b0;
            psc_exp <= '0;
        end else if (wr_cfg) begin
            src_sel <= bus_wdata[SEL_W-1:0];
            bypass  <= bus_wdata[CFG_BYP];
            psc_exp <= bus_wdata[CFG_EXP_LSB +: PSC_W];
        end
    end

    // Compare value storage, gated by run/flag state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_val <= '0;
        else if (wr_cmp)
            cmp_val <= bus_wdata[CNT_W-1:0];
    end

    // Snapshot capture of the live count on any write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_val <= '0;
        else if (wr_snap)
            snap_val <= cnt_val;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_RUN]   = ctrl.run;
                bus_rdata[CTRL_PULSE] = ctrl.pulse_mode;
                bus_rdata[CTRL_FREE]  = ctrl.free_run;
                bus_rdata[CTRL_IE]    = ctrl.irq_en;
                bus_rdata[CTRL_FLAG]  = flag;
            end
            ADDR_CFG: begin
                bus_rdata[SEL_W-1:0]            = src_sel;
                bus_rdata[CFG_BYP]              = bypass;
                bus_rdata[CFG_EXP_LSB +: PSC_W] = psc_exp;
            end
            ADDR_CMP:  bus_rdata[CNT_W-1:0] = cmp_val;
            default:   bus_rdata[CNT_W-1:0] = snap_val;
        endcase
    end
endmodule

// File: rtl/lp_cmp_timer_presc.sv
// Module: source selection, start-up synchroniser and prescaler.
// Picks one enable pulse from the source vector. After run rises, the
// first SYNC_TICKS selected pulses are swallowed, then pulses pass
// either directly (bypass) or divided by 2^(exp+1). All state clears
// while run is low. Assumes source pulses last one system clock.
module lp_cmp_timer_presc #(
    parameter int SRC_N      = 4,
    parameter int PSC_W      = 4,
    parameter int SYNC_TICKS = 2,
    localparam int SEL_W  = $clog2(SRC_N),
    localparam int PDIV_W = (1 << PSC_W) + 1,
    localparam int WARM_W = $clog2(SYNC_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SRC_N-1:0] src_tick_i,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             bypass,
    input  logic [PSC_W-1:0] psc_exp,
    output logic             cnt_tick
);
    localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(SYNC_TICKS);

    logic              sel_tick;
    logic              warm_ok;
    logic [WARM_W-1:0] warm_cnt;
    logic [PDIV_W-1:0] div_cnt;
    logic [PDIV_W-1:0] div_lim;

    // Select the active source and compute the division limit.
    always_comb begin
        sel_tick = src_tick_i[src_sel];
        warm_ok  = (warm_cnt == WARM_DONE);
        div_lim  = (PDIV_W'(1) << (32'(psc_exp) + 1)) - PDIV_W'(1);
        cnt_tick = run && sel_tick && warm_ok && (bypass || (div_cnt == div_lim));
    end

    // Warm-up counter for synchroniser start-up delay.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            warm_cnt <= '0;
        else if (sel_tick && !warm_ok)
            warm_cnt <= warm_cnt + 1'b1;
    end

    // Prescaler divider, active only after warm-up with bypass off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            div_cnt <= '0;
        else if (sel_tick && warm_ok && !bypass)
            div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + 1'b1;
    end
endmodule

// File: rtl/lp_cmp_timer_core.sv
// Module: counter, compare match and compare flag.
// On each counted tick in time mode, a count equal to the compare value
// sets the flag and either reloads zero or keeps counting (free mode).
// Pulse mode holds the count. Everything clears while run is low.
module lp_cmp_timer_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pulse_mode,
    input  logic             free_run,
    input  logic             cnt_tick,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             flag,
    output logic             match
);
    logic step;

    // Qualify ticks and detect equality.
    always_comb begin
        match = (cnt_val == cmp_val);
        step  = cnt_tick && !pulse_mode;
    end

    // Counter with reset-on-match or free-running wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_val <= '0;
        else if (step)
            cnt_val <= (match && !free_run) ? '0 : cnt_val + 1'b1;
    end

    // Sticky compare flag, set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            flag <= 1'b0;
        else if (step && match)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/lp_cmp_timer.sv
// Module: top of the low-power compare timer.
// Connects register file, prescaler and counter core, and forms the
// interrupt and trigger outputs. Assumes all sources are enable pulses
// synchronous to clk.
module lp_cmp_timer
    import lp_cmp_timer_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SRC_N      = 4,
    parameter int PSC_W      = 4,
    parameter int SYNC_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [SRC_N-1:0] src_tick_i,
    output logic             irq_o,
    output logic             trig_o
);
    localparam int SEL_W = $clog2(SRC_N);

    ctrl_t            ctrl;
    logic             run, pulse_mode;
    logic [SEL_W-1:0] src_sel;
    logic             bypass;
    logic [PSC_W-1:0] psc_exp;
    logic [CNT_W-1:0] cmp_val, cnt_val, snap_val;
    logic             flag, flag_clr, match, cnt_tick;

    lp_cmp_timer_regs #(.CNT_W(CNT_W), .SRC_N(SRC_N), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
        .flag(flag), .ctrl(ctrl), .src_sel(src_sel), .bypass(bypass),
        .psc_exp(psc_exp), .cmp_val(cmp_val), .snap_val(snap_val),
        .flag_clr(flag_clr)
    );

    lp_cmp_timer_presc #(.SRC_N(SRC_N), .PSC_W(PSC_W), .SYNC_TICKS(SYNC_TICKS)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .src_tick_i(src_tick_i),
        .src_sel(src_sel), .bypass(bypass), .psc_exp(psc_exp),
        .cnt_tick(cnt_tick)
    );

    lp_cmp_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .pulse_mode(pulse_mode),
        .free_run(ctrl.free_run), .cnt_tick(cnt_tick), .flag_clr(flag_clr),
        .cmp_val(cmp_val), .cnt_val(cnt_val), .flag(flag), .match(match)
    );

    // Unpack control fields and drive the outputs.
    always_comb begin
        run        = ctrl.run;
        pulse_mode = ctrl.pulse_mode;
        irq_o      = flag && ctrl.irq_en;
        trig_o     = run && match;
    end
endmodule

// File: rtl/lp_cmp_timer_chk.sv
// Module: assertion checker for the compare timer, bound to the top.
module lp_cmp_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             run,
    input logic             pulse_mode,
    input logic             flag,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] snap_val,
    input logic             irq_o,
    input logic             trig_o
);
    // R11: a stopped timer has zero count and no flag one cycle later.
    a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_val == '0) && !flag);

    // R10: compare value frozen while running with flag clear.
    a_r10_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !flag) |=> $stable(cmp_val));

    // R5: snapshot changes only after a write to its address.
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd3) |=> $stable(snap_val));

    // R12: pulse mode holds the count while running.
    a_r12_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pulse_mode) |=> $stable(cnt_val));

    // R9: no trigger while stopped.
    a_r9_trig_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !trig_o);

    // R6: the flag can only rise while the timer was running.
    a_r6_flag_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(run));

    // R8: interrupt only with the flag set.
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);
endmodule

bind lp_cmp_timer lp_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .run(run), .pulse_mode(pulse_mode), .flag(flag), .cnt_val(cnt_val),
    .cmp_val(cmp_val), .snap_val(snap_val), .irq_o(irq_o), .trig_o(trig_o)
);

// File: tb/lp_cmp_timer_bench.sv
module lp_cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick_i = '0;
    logic        irq_o, trig_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // Control word encodings: bit0 run, bit1 pulse, bit2 free, bit3 ie, bit7 flag.
    localparam logic [31:0] RUN = 32'h1, PULSE = 32'h2, FREE = 32'h4, IE = 32'h8, FLG = 32'h80;

    lp_cmp_timer u_lp_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick_i(src_tick_i),
        .irq_o(irq_o), .trig_o(trig_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic snap(output logic [31:0] d);
        wr(2'd3, 32'hDEAD);
        rd(2'd3, d);
    endtask

    task automatic ticks(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_tick_i[src] = 1'b1;
            @(negedge clk); src_tick_i = '0;
        end
    endtask

    task automatic sample_outs(output logic i, output logic t);
        @(negedge clk); #1 i = irq_o; t = trig_o;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reg after reset", d, 0);
        end
        check("R1 irq", {31'd0, irq_o}, 0);
        check("R1 trig", {31'd0, trig_o}, 0);
    endtask

    task automatic t_select_bypass;
        logic [31:0] d;
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h6);              // source 2, bypass
        wr(2'd0, RUN | FREE);
        ticks(2, 2);
        snap(d); check("R4 warm-up pulses not counted", d, 0);
        ticks(2, 5);
        ticks(0, 3);
        ticks(3, 2);
        snap(d); check("R2 R3 bypass counts selected only", d, 5);
        ticks(2, 1);
        rd(2'd3, d); check("R5 snapshot holds", d, 5);
        snap(d); check("R5 new capture", d, 6);
        wr(2'd0, 32'h0);
        snap(d); check("R11 stop clears count", d, 0);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        wr(2'd1, 32'h0A);             // source 2, exponent 1 -> divide by 4
        wr(2'd0, RUN | FREE);
        ticks(2, 2 + 9);
        snap(d); check("R3 divide by four", d, 2);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_compare_reset;
        logic [31:0] d; logic i, t;
        wr(2'd1, 32'h6);
        wr(2'd2, 32'd3);
        wr(2'd0, RUN | IE);
        ticks(2, 2 + 3);
        sample_outs(i, t);
        check("R9 trig at match", {31'd0, t}, 1);
        check("R8 no irq before flag", {31'd0, i}, 0);
        wr(2'd2, 32'd9);
        rd(2'd2, d); check("R10 cmp write ignored", d, 3);
        ticks(2, 1);
        rd(2'd0, d); check("R6 flag set", d & FLG, FLG);
        sample_outs(i, t);
        check("R8 irq with flag", {31'd0, i}, 1);
        snap(d); check("R7 reset on match", d, 0);
        wr(2'd2, 32'd9);
        rd(2'd2, d); check("R10 cmp write with flag", d, 9);
        wr(2'd0, RUN | IE);
        rd(2'd0, d); check("R6 write 0 keeps flag", d & FLG, FLG);
        wr(2'd0, RUN | IE | FLG);
        rd(2'd0, d); check("R6 w1c clears flag", d & FLG, 0);
        ticks(2, 1);
        rd(2'd0, d); check("R6 flag stays clear", d & FLG, 0);
        wr(2'd0, RUN);
        sample_outs(i, t);
        check("R8 irq off without enable", {31'd0, i}, 0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_free;
        logic [31:0] d;
        wr(2'd2, 32'd2);
        wr(2'd0, RUN | FREE);
        ticks(2, 2 + 3);
        rd(2'd0, d); check("R6 flag in free mode", d & FLG, FLG);
        snap(d); check("R7 free mode keeps counting", d, 3);
        wr(2'd0, 32'h0);
        rd(2'd0, d); check("R11 stop clears flag", d & FLG, 0);
        rd(2'd3, d); check("R11 snapshot retained", d, 3);
    endtask

    task automatic t_zero_cmp;
        logic i, t;
        wr(2'd2, 32'd0);
        wr(2'd0, RUN);
        ticks(2, 2 + 4);
        sample_outs(i, t);
        check("R9 zero compare holds trig", {31'd0, t}, 1);
        wr(2'd0, 32'h0);
        sample_outs(i, t);
        check("R9 trig drops on stop", {31'd0, t}, 0);
    endtask

    task automatic t_pulse;
        logic [31:0] d;
        wr(2'd2, 32'hFFFF);
        wr(2'd0, RUN | FREE);
        ticks(2, 2 + 3);
        wr(2'd0, RUN | FREE | PULSE);
        ticks(2, 4);
        snap(d); check("R12 pulse mode holds", d, 3);
        wr(2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select_bypass();
        t_prescale();
        t_compare_reset();
        t_free();
        t_zero_cmp();
        t_pulse();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule